// File: doc/BRIEF.md
# Legacy Replacement Interrupt Router

This block turns the match events of a bank of timer channels into interrupt activity. Each channel raises assert and deassert requests. A channel in level mode holds a line high, and a channel in edge mode pulses a line for one cycle. A channel can instead send its event as a memory-write message. The message address and data come from that channel's 64-bit message word, and a downstream bus master consumes it over a valid/ready handshake.

Two legacy inputs are also routed by this block: a periodic-timer input and a real-time-clock input. In normal mode they pass through to fixed lines 0 and 8. When legacy replacement mode is selected, timer 0 and timer 1 take over those two lines. The legacy inputs are then blocked, and the periodic-timer enable output is withdrawn.

Two state machines control the block. The mode machine has the states MODE_NORMAL and MODE_LEGACY. It takes the transition "enter" (MODE_NORMAL to MODE_LEGACY) when `legacy_mode` is sampled high, and the transition "leave" (MODE_LEGACY to MODE_NORMAL) when it is sampled low. The message arbiter has the states ARB_IDLE and ARB_SEND. It takes the transition "grant" (ARB_IDLE to ARB_SEND) when any message is pending, and the transition "retire" (ARB_SEND to ARB_IDLE) when `msg_ready` is high.

Top module: `irq_legacy_router`

## Requirements
- R1: In legacy mode, channel 0 targets line 0 and channel 1 targets line 8, regardless of their route fields. Every other channel, and channels 0 and 1 in normal mode, target the line given by the 5-bit route field `ch_route[5c+4:5c]`. The mode in effect is the value of `legacy_mode` sampled at the previous clock edge.
- R2: A level channel (`ch_level[c]`=1) that asserts without message delivery drives its line high from the next cycle on. The line stays high until a deassert from a channel aimed at that line. If an assert and a deassert reach the same line in the same cycle, the assert wins.
- R3: An edge channel (`ch_level[c]`=0) that asserts without message delivery drives its line high for exactly one cycle, in the cycle after the request.
- R4: When a channel asserts with `ch_msg_en[c]`=1, the block issues one message whose address is `ch_msg_word[64c+63:64c+32]` and whose data is `ch_msg_word[64c+31:64c]`. The channel's line is not driven.
- R5: A deassert from a channel with `ch_msg_en[c]`=1 leaves every line unchanged.
- R6: In normal mode, line 0 repeats `pit_in` and line 8 repeats `rtc_in`, each one cycle late. Each of these lines is also ORed with any channel activity on that line.
- R7: One cycle after `legacy_mode` rises, `pit_en` is low, the legacy inputs no longer reach lines 0 and 8, and any held level on lines 0 and 8 is cleared.
- R8: One cycle after `legacy_mode` falls, `pit_en` is high and held levels on lines 0 and 8 are cleared. Line 8 then shows the last sampled `rtc_in` level.
- R9: During and after reset, all lines are low, `pit_en` is high, `msg_valid` is low, and the remembered real-time-clock level is 0.
- R10: Messages requested together are issued one at a time, lowest channel index first. While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_set | input | 32 | Per-channel assert request |
| ev_clr | input | 32 | Per-channel deassert request |
| ch_level | input | 32 | Per-channel type: 1 level, 0 edge |
| ch_msg_en | input | 32 | Per-channel message delivery enable |
| ch_route | input | 160 | Per-channel 5-bit target line, channel c at bits 5c+4:5c |
| ch_msg_word | input | 2048 | Per-channel message word: address in the upper 32 bits, data in the lower 32 bits |
| legacy_mode | input | 1 | Legacy replacement mode select |
| pit_in | input | 1 | Periodic-timer legacy interrupt input |
| rtc_in | input | 1 | Real-time-clock legacy interrupt input |
| msg_ready | input | 1 | Message consumer ready |
| irq_line | output | 32 | Interrupt output lines |
| pit_en | output | 1 | Periodic-timer enable |
| msg_valid | output | 1 | Message valid |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
Routing is tried with the same channels in both modes, so that line 17 compared with line 0, and line 18 compared with line 8, shows whether the route field or the legacy override decided. Level, edge and message-enabled requests aimed at one shared line separate held levels, one-cycle pulses and suppressed line activity. Combined assert-and-deassert requests show which of the two wins. The mode switches are made with the legacy inputs high and with held levels present on lines 0 and 8, so that passthrough blocking, clearing of held levels and restoration of the remembered clock level are each seen on their own. Three messages requested in one cycle while `msg_ready` is low show both the issue order and that the offered message stays stable.

// File: rtl/lrr_pkg.sv
package lrr_pkg;
    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_LEGACY = 1'b1
    } mode_e;

    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_SEND = 1'b1
    } arb_e;

    localparam int MSG_W  = 64;
    localparam int HALF_W = MSG_W / 2;
endpackage

// File: rtl/lrr_decode.sv
module lrr_decode #(
    parameter int N_CH         = 32,
    parameter int N_LINES      = 32,
    parameter int LEG_TMR_LINE = 0,
    parameter int LEG_RTC_LINE = 8,
    localparam int RW          = $clog2(N_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_legacy,
    input  logic [N_CH-1:0]      ev_set,
    input  logic [N_CH-1:0]      ev_clr,
    input  logic [N_CH-1:0]      ch_level,
    input  logic [N_CH-1:0]      ch_msg_en,
    input  logic [N_CH*RW-1:0]   ch_route,
    output logic [N_LINES-1:0]   set_lvl,
    output logic [N_LINES-1:0]   set_edge,
    output logic [N_LINES-1:0]   clr_lvl,
    output logic [N_CH-1:0]      msg_req
);
    logic [RW-1:0] dest [N_CH];

    // Target line per channel; channels 0 and 1 are overridden in legacy mode (R1)
    for (genvar c = 0; c < N_CH; c++) begin : g_dest
        if (c == 0) begin : g_tmr
            assign dest[c] = in_legacy ? RW'(LEG_TMR_LINE) : ch_route[c*RW +: RW];
        end else if (c == 1) begin : g_rtc
            assign dest[c] = in_legacy ? RW'(LEG_RTC_LINE) : ch_route[c*RW +: RW];
        end else begin : g_plain
            assign dest[c] = ch_route[c*RW +: RW];
        end
    end

    always_comb begin
        set_lvl  = '0;
        set_edge = '0;
        clr_lvl  = '0;
        for (int c = 0; c < N_CH; c++) begin
            if (ev_set[c] && !ch_msg_en[c]) begin
                if (ch_level[c]) set_lvl[dest[c]]  = 1'b1;
                else             set_edge[dest[c]] = 1'b1;
            end
            if (ev_clr[c] && !ch_msg_en[c]) clr_lvl[dest[c]] = 1'b1;
        end
    end

    assign msg_req = ev_set & ch_msg_en;

    // R4: message-enabled requests never touch a line
    p_msg_no_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_set & ~ch_msg_en) == '0) |-> ((set_lvl | set_edge) == '0));

    // R1: channel 0 forced onto the timer legacy line
    p_t0_forced_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_legacy && ev_set[0] && !ch_msg_en[0] && ch_level[0]) |-> set_lvl[LEG_TMR_LINE]);
endmodule

// File: rtl/lrr_lines.sv
module lrr_lines
    import lrr_pkg::*;
#(
    parameter int N_LINES      = 32,
    parameter int LEG_TMR_LINE = 0,
    parameter int LEG_RTC_LINE = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               legacy_mode,
    input  logic               pit_in,
    input  logic               rtc_in,
    input  logic [N_LINES-1:0] set_lvl,
    input  logic [N_LINES-1:0] set_edge,
    input  logic [N_LINES-1:0] clr_lvl,
    output logic [N_LINES-1:0] irq_line,
    output logic               pit_en,
    output logic               in_legacy
);
    localparam logic [N_LINES-1:0] LEG_MASK =
        (N_LINES'(1) << LEG_TMR_LINE) | (N_LINES'(1) << LEG_RTC_LINE);

    mode_e              state_q, state_d;
    logic               mode_flip;
    logic [N_LINES-1:0] hold_q;
    logic [N_LINES-1:0] pulse_q;
    logic               pit_q;
    logic               rtc_mem_q;

    // Next-state logic: enter / leave
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_NORMAL: if (legacy_mode)  state_d = MODE_LEGACY;
            MODE_LEGACY: if (!legacy_mode) state_d = MODE_NORMAL;
            default:                       state_d = MODE_NORMAL;
        endcase
    end

    assign mode_flip = (state_d != state_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_NORMAL;
        else        state_q <= state_d;
    end

    // Line storage: held levels, one-cycle pulses, sampled legacy inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            pulse_q   <= '0;
            pit_q     <= 1'b0;
            rtc_mem_q <= 1'b0;
        end else begin
            hold_q    <= ((hold_q & ~clr_lvl) | set_lvl) & ~(mode_flip ? LEG_MASK : '0);
            pulse_q   <= set_edge;
            pit_q     <= pit_in;
            rtc_mem_q <= rtc_in;
        end
    end

    // Outputs
    always_comb begin
        irq_line  = hold_q | pulse_q;
        pit_en    = 1'b1;
        in_legacy = 1'b0;
        unique case (state_q)
            MODE_NORMAL: begin
                irq_line[LEG_TMR_LINE] = irq_line[LEG_TMR_LINE] | pit_q;
                irq_line[LEG_RTC_LINE] = irq_line[LEG_RTC_LINE] | rtc_mem_q;
            end
            MODE_LEGACY: begin
                pit_en    = 1'b0;
                in_legacy = 1'b1;
            end
            default: ;
        endcase
    end

    // R7: entering legacy drops the enable
    p_enter_pit_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_mode |=> !pit_en);

    // R8: leaving legacy restores the enable
    p_leave_pit_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !legacy_mode |=> pit_en);

    // R7: held levels on the legacy lines are cleared on entry
    p_enter_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_NORMAL && legacy_mode) |=>
            (!hold_q[LEG_TMR_LINE] && !hold_q[LEG_RTC_LINE]));
endmodule

// File: rtl/lrr_msg_arb.sv
module lrr_msg_arb
    import lrr_pkg::*;
#(
    parameter int N_CH = 32,
    localparam int CW  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_CH-1:0]       msg_req,
    input  logic [N_CH*MSG_W-1:0] ch_msg_word,
    input  logic                  msg_ready,
    output logic                  msg_valid,
    output logic [HALF_W-1:0]     msg_addr,
    output logic [HALF_W-1:0]     msg_data
);
    arb_e              state_q, state_d;
    logic [N_CH-1:0]   pending_q;
    logic [N_CH-1:0]   grant_oh;
    logic [CW-1:0]     grant_q;
    logic [CW-1:0]     pick;
    logic              has_pend;
    logic              done;
    logic [HALF_W-1:0] addr_q, data_q;

    // Lowest pending index
    always_comb begin
        pick = '0;
        for (int c = N_CH - 1; c >= 0; c--) begin
            if (pending_q[c]) pick = CW'(c);
        end
    end

    assign has_pend = |pending_q;
    assign done     = (state_q == ARB_SEND) && msg_ready;
    assign grant_oh = done ? (N_CH'(1) << grant_q) : '0;

    // Next-state logic: grant / retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: if (has_pend)  state_d = ARB_SEND;
            ARB_SEND: if (msg_ready) state_d = ARB_IDLE;
            default:                 state_d = ARB_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= '0;
            grant_q   <= '0;
            addr_q    <= '0;
            data_q    <= '0;
        end else begin
            pending_q <= (pending_q & ~grant_oh) | msg_req;
            if (state_q == ARB_IDLE && has_pend) begin
                grant_q <= pick;
                addr_q  <= ch_msg_word[pick*MSG_W + HALF_W +: HALF_W];
                data_q  <= ch_msg_word[pick*MSG_W +: HALF_W];
            end
        end
    end

    // Outputs
    always_comb begin
        msg_valid = 1'b0;
        unique case (state_q)
            ARB_IDLE: msg_valid = 1'b0;
            ARB_SEND: msg_valid = 1'b1;
            default:  msg_valid = 1'b0;
        endcase
    end
    assign msg_addr = addr_q;
    assign msg_data = data_q;

    // R10: an offered message stays put while stalled
    p_stall_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    // R4: pending work is offered on the next cycle
    p_pending_served_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_IDLE && has_pend) |=> msg_valid);

    // R10: the channel being offered is still pending
    p_grant_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> pending_q[grant_q]);
endmodule

// File: rtl/irq_legacy_router.sv
module irq_legacy_router
    import lrr_pkg::*;
#(
    parameter int N_CH         = 32,
    parameter int N_LINES      = 32,
    parameter int LEG_TMR_LINE = 0,
    parameter int LEG_RTC_LINE = 8,
    localparam int RW          = $clog2(N_LINES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_CH-1:0]       ev_set,
    input  logic [N_CH-1:0]       ev_clr,
    input  logic [N_CH-1:0]       ch_level,
    input  logic [N_CH-1:0]       ch_msg_en,
    input  logic [N_CH*RW-1:0]    ch_route,
    input  logic [N_CH*MSG_W-1:0] ch_msg_word,
    input  logic                  legacy_mode,
    input  logic                  pit_in,
    input  logic                  rtc_in,
    input  logic                  msg_ready,
    output logic [N_LINES-1:0]    irq_line,
    output logic                  pit_en,
    output logic                  msg_valid,
    output logic [HALF_W-1:0]     msg_addr,
    output logic [HALF_W-1:0]     msg_data
);
    logic               in_legacy;
    logic [N_LINES-1:0] set_lvl, set_edge, clr_lvl;
    logic [N_CH-1:0]    msg_req;

    lrr_decode #(
        .N_CH(N_CH), .N_LINES(N_LINES),
        .LEG_TMR_LINE(LEG_TMR_LINE), .LEG_RTC_LINE(LEG_RTC_LINE)
    ) u_decode (
        .clk(clk), .rst_n(rst_n), .in_legacy(in_legacy),
        .ev_set(ev_set), .ev_clr(ev_clr), .ch_level(ch_level),
        .ch_msg_en(ch_msg_en), .ch_route(ch_route),
        .set_lvl(set_lvl), .set_edge(set_edge), .clr_lvl(clr_lvl),
        .msg_req(msg_req)
    );

    lrr_lines #(
        .N_LINES(N_LINES),
        .LEG_TMR_LINE(LEG_TMR_LINE), .LEG_RTC_LINE(LEG_RTC_LINE)
    ) u_lines (
        .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode),
        .pit_in(pit_in), .rtc_in(rtc_in),
        .set_lvl(set_lvl), .set_edge(set_edge), .clr_lvl(clr_lvl),
        .irq_line(irq_line), .pit_en(pit_en), .in_legacy(in_legacy)
    );

    lrr_msg_arb #(.N_CH(N_CH)) u_arb (
        .clk(clk), .rst_n(rst_n), .msg_req(msg_req),
        .ch_msg_word(ch_msg_word), .msg_ready(msg_ready),
        .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data)
    );
endmodule

// File: tb/irq_legacy_router_tb.sv
`timescale 1ns/1ps
module irq_legacy_router_tb;
    logic          clk = 1'b0;
    logic          rst_n;
    logic [31:0]   ev_set, ev_clr, ch_level, ch_msg_en;
    logic [159:0]  ch_route;
    logic [2047:0] ch_msg_word;
    logic          legacy_mode, pit_in, rtc_in, msg_ready;
    logic [31:0]   irq_line;
    logic          pit_en, msg_valid;
    logic [31:0]   msg_addr, msg_data;

    int total = 0;
    int bad   = 0;
    int delivered = 0;
    bit finished = 0;
    logic [63:0] exp_q[$];

    always #2.5 clk = ~clk;

    irq_legacy_router u_dut (
        .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .ev_clr(ev_clr),
        .ch_level(ch_level), .ch_msg_en(ch_msg_en), .ch_route(ch_route),
        .ch_msg_word(ch_msg_word), .legacy_mode(legacy_mode),
        .pit_in(pit_in), .rtc_in(rtc_in), .msg_ready(msg_ready),
        .irq_line(irq_line), .pit_en(pit_en), .msg_valid(msg_valid),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_chan(input int c, input logic lvl, input logic men, input logic [4:0] rt);
        ch_level[c]      = lvl;
        ch_msg_en[c]     = men;
        ch_route[c*5 +: 5] = rt;
    endtask

    // Driver side of the scoreboard: arm a message request and queue its expectation
    task automatic arm_msg(input int c, input logic [31:0] a, input logic [31:0] d);
        ch_msg_word[c*64 +: 64] = {a, d};
        ch_msg_en[c] = 1'b1;
        ev_set[c]    = 1'b1;
        exp_q.push_back({a, d});
    endtask

    // Monitor side: every completed handshake is compared with the queue head
    always @(negedge clk) begin
        if (rst_n === 1'b1 && msg_valid && msg_ready) begin
            delivered++;
            if (exp_q.size() == 0) begin
                check("R4 unexpected message", {msg_addr, msg_data}, 64'h0);
            end else begin
                check("R4/R10 message content and order", {msg_addr, msg_data}, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        ev_set = '0; ev_clr = '0; ch_level = '0; ch_msg_en = '0;
        ch_route = '0; ch_msg_word = '0;
        legacy_mode = 1'b0; pit_in = 1'b0; rtc_in = 1'b0; msg_ready = 1'b1;
        repeat (3) tick();
        check("R9 lines in reset", 64'(irq_line), 64'h0);
        check("R9 pit_en in reset", 64'(pit_en), 64'h1);
        rst_n = 1'b1;
        tick();
        check("R9 lines after reset", 64'(irq_line), 64'h0);
        check("R9 pit_en after reset", 64'(pit_en), 64'h1);
        check("R9 no message after reset", 64'(msg_valid), 64'h0);

        // R6 passthrough in normal mode
        pit_in = 1'b1;
        tick();
        check("R6 line0 follows pit_in", 64'(irq_line), 64'h1);
        pit_in = 1'b0; rtc_in = 1'b1;
        tick();
        check("R6 line8 follows rtc_in", 64'(irq_line), 64'h100);
        rtc_in = 1'b0;
        tick();
        check("R6 lines drop with inputs", 64'(irq_line), 64'h0);

        // R2 level hold
        set_chan(3, 1'b1, 1'b0, 5'd12);
        ev_set[3] = 1'b1;
        tick();
        ev_set[3] = 1'b0;
        check("R2 level raised", 64'(irq_line), 64'h1000);
        tick(); tick();
        check("R2 level held", 64'(irq_line), 64'h1000);
        ev_clr[3] = 1'b1;
        tick();
        ev_clr[3] = 1'b0;
        check("R2 level cleared", 64'(irq_line), 64'h0);
        ev_set[3] = 1'b1; ev_clr[3] = 1'b1;
        tick();
        ev_set[3] = 1'b0; ev_clr[3] = 1'b0;
        check("R2 set wins over clear", 64'(irq_line), 64'h1000);
        ev_clr[3] = 1'b1;
        tick();
        ev_clr[3] = 1'b0;

        // R3 edge pulse
        set_chan(5, 1'b0, 1'b0, 5'd20);
        ev_set[5] = 1'b1;
        tick();
        ev_set[5] = 1'b0;
        check("R3 edge pulse high", 64'(irq_line), 64'h100000);
        tick();
        check("R3 edge pulse gone", 64'(irq_line), 64'h0);

        // R1 channel 0 follows its route field in normal mode
        set_chan(0, 1'b1, 1'b0, 5'd17);
        ev_set[0] = 1'b1;
        tick();
        ev_set[0] = 1'b0;
        check("R1 ch0 uses route in normal mode", 64'(irq_line), 64'h20000);
        ev_clr[0] = 1'b1;
        tick();
        ev_clr[0] = 1'b0;

        // R7 enter legacy with inputs high and a held level on line 0
        set_chan(2, 1'b1, 1'b0, 5'd0);
        ev_set[2] = 1'b1; pit_in = 1'b1; rtc_in = 1'b1;
        tick();
        ev_set[2] = 1'b0;
        check("R6 lines 0 and 8 before entry", 64'(irq_line), 64'h101);
        legacy_mode = 1'b1;
        tick();
        check("R7 pit_en low after entry", 64'(pit_en), 64'h0);
        check("R7 lines 0 and 8 low after entry", 64'(irq_line), 64'h0);

        // R1 overrides inside legacy mode
        ev_set[0] = 1'b1;
        tick();
        ev_set[0] = 1'b0;
        check("R1 ch0 forced to line0", 64'(irq_line), 64'h1);
        set_chan(1, 1'b0, 1'b0, 5'd18);
        ev_set[1] = 1'b1;
        tick();
        ev_set[1] = 1'b0;
        check("R1 ch1 forced to line8", 64'(irq_line), 64'h101);
        tick();
        check("R7 rtc blocked in legacy", 64'(irq_line), 64'h1);
        set_chan(4, 1'b1, 1'b0, 5'd9);
        ev_set[4] = 1'b1;
        tick();
        ev_set[4] = 1'b0;
        check("R1 other channel uses route", 64'(irq_line), 64'h201);
        ev_clr[4] = 1'b1;
        ch_level[1] = 1'b1; ev_set[1] = 1'b1;
        tick();
        ev_clr[4] = 1'b0; ev_set[1] = 1'b0;
        check("R1 ch1 level hold on line8", 64'(irq_line), 64'h101);

        // R8 leave legacy
        pit_in = 1'b0;
        legacy_mode = 1'b0;
        tick();
        check("R8 pit_en high after leave", 64'(pit_en), 64'h1);
        check("R8 line0 low, line8 remembered rtc", 64'(irq_line), 64'h100);
        rtc_in = 1'b0;
        tick();
        check("R8 held line8 cleared on leave", 64'(irq_line), 64'h0);

        // R5 and R4: message-enabled channels on a shared line
        set_chan(7, 1'b1, 1'b0, 5'd25);
        ev_set[7] = 1'b1;
        tick();
        ev_set[7] = 1'b0;
        set_chan(8, 1'b1, 1'b1, 5'd25);
        ev_clr[8] = 1'b1;
        tick();
        ev_clr[8] = 1'b0;
        check("R5 message deassert leaves line", 64'(irq_line), 64'h2000000);
        set_chan(6, 1'b1, 1'b0, 5'd25);
        set_chan(9, 1'b0, 1'b0, 5'd3);
        arm_msg(6, 32'hFEE0_1000, 32'h0000_0041);
        arm_msg(9, 32'hFEE0_2000, 32'h0000_0052);
        tick();
        ev_set = '0;
        check("R4 message assert drives no line", 64'(irq_line), 64'h2000000);
        repeat (6) tick();
        ev_clr[7] = 1'b1;
        tick();
        ev_clr[7] = 1'b0;
        check("R2 shared line cleared", 64'(irq_line), 64'h0);

        // R10 ordering and stall stability
        msg_ready = 1'b0;
        ch_msg_word[30*64 +: 64] = 64'h0;
        ev_set[30] = 1'b1; ch_msg_en[30] = 1'b1;
        ev_set[10] = 1'b1; ch_msg_en[10] = 1'b1;
        ev_set[4]  = 1'b1; ch_msg_en[4]  = 1'b1;
        ch_msg_word[4*64 +: 64]  = 64'h1111_0004_AAAA_0004;
        ch_msg_word[10*64 +: 64] = 64'h1111_000A_AAAA_000A;
        ch_msg_word[30*64 +: 64] = 64'h1111_001E_AAAA_001E;
        exp_q.push_back(64'h1111_0004_AAAA_0004);
        exp_q.push_back(64'h1111_000A_AAAA_000A);
        exp_q.push_back(64'h1111_001E_AAAA_001E);
        tick();
        ev_set = '0;
        repeat (3) tick();
        check("R10 valid held while stalled", 64'(msg_valid), 64'h1);
        check("R10 lowest index offered first", {msg_addr, msg_data}, 64'h1111_0004_AAAA_0004);
        tick();
        check("R10 offer stable under stall", {msg_addr, msg_data}, 64'h1111_0004_AAAA_0004);
        msg_ready = 1'b1;
        repeat (10) tick();
        check("R10 all messages drained", 64'(exp_q.size()), 64'h0);
        check("R4 one message per request", 64'(delivered), 64'd5);
        check("R4 no line from messages", 64'(irq_line), 64'h0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule